// File: doc/BRIEF.md
# Display Memory Cycle Sequencer

This block shares a four-plane display memory between the display refresh path and the host processor. Each character period is split into a fixed number of memory slots, and a free-running slot counter paces the periods and produces the character clock. During active display the refresh path owns every slot except one reserved slot. That slot goes to the host whenever a host request is waiting, so the host reaches memory in the middle of a visible line instead of stalling until blanking. During blanking the host may take any slot.

Each granted cycle is issued to the plane memories one clock later as an address, per-plane read enables and per-plane write enables. A 4-bit plane write mask is taken at the moment a host write is granted. A plane whose mask bit is clear is not written by that cycle. Each plane holds 64 KB, so the address is 16 bits wide.

Top module: `dmseq_top`

## Requirements
- R1: The slot counter is 0 after reset and steps 0, 1, …, SLOTS-1, 0, … once per clock. `char_clk` is high while the slot number is below SLOTS/2 and low otherwise.
- R2: While `active` is high, `host_ack` is asserted only in slot HOST_SLOT, which defaults to SLOTS-1.
- R3: While `active` is high, a display request in any slot other than HOST_SLOT is granted in that same cycle (`disp_ack` high), whether or not a host request is waiting.
- R4: While `active` is high, a display request in slot HOST_SLOT is granted when no host request is waiting, and refused when one is.
- R5: While `active` is low, a waiting host request is granted in whatever slot it falls in and takes priority over a display request in the same cycle.
- R6: `host_ack` is combinational. It is high only in a cycle in which `host_req` is high and the slot rules above grant it. It stays low for a waiting request until that request is granted.
- R7: One clock after a grant, `mem_cyc` is high. `mem_host` is 1 for a host cycle and 0 for a display cycle, and `mem_addr` carries the granted request's address.
- R8: One clock after a host write is granted, `mem_we` equals the `map_mask` value present in the grant cycle. Bit i of `mem_we` enables plane i. A mask of 0 writes no plane.
- R9: A display cycle and a host read cycle drive `mem_re` to 4'b1111 and `mem_we` to 0. A host write cycle drives `mem_re` to 0.
- R10: In a cycle after no grant, and during reset, `mem_cyc`, `mem_host`, `mem_we`, `mem_re` and `mem_addr` are all 0.
- R11: A change to `map_mask` while a host write is waiting affects that write only if the change comes before or in its grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active | input | 1 | High during the active display interval |
| disp_req | input | 1 | Display fetch request |
| disp_addr | input | 16 | Display fetch address |
| disp_ack | output | 1 | Display fetch granted this cycle |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 16 | Host access address |
| map_mask | input | 4 | Per-plane host write enable mask |
| host_ack | output | 1 | Host access granted this cycle |
| char_clk | output | 1 | Character clock derived from the slot counter |
| mem_cyc | output | 1 | A memory cycle is issued this clock |
| mem_host | output | 1 | The issued cycle belongs to the host |
| mem_addr | output | 16 | Plane address of the issued cycle |
| mem_we | output | 4 | Per-plane write enables |
| mem_re | output | 4 | Per-plane read enables |

## Verification
The bench holds host requests waiting across whole character periods. A design that let the host into an ordinary slot during active display would delay a display fetch, and one that ignored the reserved slot would never acknowledge the host. It places display requests exactly on the reserved slot with and without a waiting host, which shows up a fixed owner for that slot in either direction. It also changes the plane mask while a write is waiting and switches between active and blanking at random. Mask capture at request time rather than grant time would then write the wrong planes, and a sequencer that treated blanking like active display would hold host requests back needlessly.

// File: rtl/dmseq_pkg.sv
package dmseq_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_DISP = 2'd1,
    OWN_HOST = 2'd2
  } owner_e;

  // character clock level for a given slot of an n-slot period
  function automatic logic char_level(input int unsigned s, input int unsigned n);
    return s < (n / 2);
  endfunction

  // next slot number with wrap at n
  function automatic int unsigned slot_next(input int unsigned s, input int unsigned n);
    return (s + 1 >= n) ? 0 : s + 1;
  endfunction

endpackage

// File: rtl/dmseq_slot_timer.sv
module dmseq_slot_timer #(
  parameter int SLOTS = 8,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot,
  output logic          char_clk,
  output logic          period_end
);
  import dmseq_pkg::*;

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= SW'(slot_next(32'(slot_q), SLOTS));
  end

  assign slot       = slot_q;
  assign period_end = (slot_q == SW'(SLOTS - 1));
  assign char_clk   = char_level(32'(slot_q), SLOTS);

  // R1
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (slot_q == '0));

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> (slot_q != '0));

endmodule

// File: rtl/dmseq_arbiter.sv
module dmseq_arbiter #(
  parameter int SLOTS     = 8,
  parameter int HOST_SLOT = SLOTS - 1,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [SW-1:0]     slot,
  input  logic              host_req,
  input  logic              disp_req,
  output logic              host_slot_open,
  output logic              host_gnt,
  output logic              disp_gnt,
  output dmseq_pkg::owner_e owner
);
  import dmseq_pkg::*;

  logic reserved_slot;

  assign reserved_slot  = (slot == SW'(HOST_SLOT));
  // blanking opens every slot, active display only the reserved one
  assign host_slot_open = !active || reserved_slot;
  assign host_gnt       = host_req && host_slot_open;
  assign disp_gnt       = disp_req && !host_gnt;

  always_comb begin
    if (host_gnt)      owner = OWN_HOST;
    else if (disp_gnt) owner = OWN_DISP;
    else               owner = OWN_NONE;
  end

  // R3
  disp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && disp_req && !reserved_slot) |-> disp_gnt);

  // R6
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> host_req);

endmodule

// File: rtl/dmseq_plane_issue.sv
module dmseq_plane_issue #(
  parameter int PLANES = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dmseq_pkg::owner_e owner,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [ADDR_W-1:0] disp_addr,
  input  logic [PLANES-1:0] map_mask,
  output logic              mem_cyc,
  output logic              mem_host,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PLANES-1:0] mem_we,
  output logic [PLANES-1:0] mem_re
);
  import dmseq_pkg::*;

  function automatic logic [PLANES-1:0] write_lanes(input logic [PLANES-1:0] m,
                                                    input logic w);
    return m & {PLANES{w}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_cyc  <= 1'b0;
      mem_host <= 1'b0;
      mem_addr <= '0;
      mem_we   <= '0;
      mem_re   <= '0;
    end else begin
      unique case (owner)
        OWN_HOST: begin
          mem_cyc  <= 1'b1;
          mem_host <= 1'b1;
          mem_addr <= host_addr;
          mem_we   <= write_lanes(map_mask, host_we);
          mem_re   <= {PLANES{!host_we}};
        end
        OWN_DISP: begin
          mem_cyc  <= 1'b1;
          mem_host <= 1'b0;
          mem_addr <= disp_addr;
          mem_we   <= '0;
          mem_re   <= '1;
        end
        default: begin
          mem_cyc  <= 1'b0;
          mem_host <= 1'b0;
          mem_addr <= '0;
          mem_we   <= '0;
          mem_re   <= '0;
        end
      endcase
    end
  end

  // R8
  we_needs_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> mem_host);

  // R8
  mask_at_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_HOST) |=> (mem_we == ($past(map_mask) & {PLANES{$past(host_we)}})));

  // R9
  disp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_DISP) |=> (mem_re == '1 && mem_we == '0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE) |=> (!mem_cyc && mem_we == '0 && mem_re == '0));

endmodule

// File: rtl/dmseq_top.sv
module dmseq_top #(
  parameter int SLOTS     = 8,
  parameter int HOST_SLOT = SLOTS - 1,
  parameter int PLANES    = 4,
  parameter int PLANE_KB  = 64,
  localparam int ADDR_W = $clog2(PLANE_KB * 1024),
  localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              disp_req,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic              disp_ack,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [PLANES-1:0] map_mask,
  output logic              host_ack,
  output logic              char_clk,
  output logic              mem_cyc,
  output logic              mem_host,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PLANES-1:0] mem_we,
  output logic [PLANES-1:0] mem_re
);
  import dmseq_pkg::*;

  logic [SW-1:0] slot;
  logic          period_end;
  logic          host_slot_open;
  logic          host_gnt;
  logic          disp_gnt;
  owner_e        owner;

  dmseq_slot_timer #(.SLOTS(SLOTS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot       (slot),
    .char_clk   (char_clk),
    .period_end (period_end)
  );

  dmseq_arbiter #(.SLOTS(SLOTS), .HOST_SLOT(HOST_SLOT)) u_arb (
    .clk            (clk),
    .rst_n          (rst_n),
    .active         (active),
    .slot           (slot),
    .host_req       (host_req),
    .disp_req       (disp_req),
    .host_slot_open (host_slot_open),
    .host_gnt       (host_gnt),
    .disp_gnt       (disp_gnt),
    .owner          (owner)
  );

  dmseq_plane_issue #(.PLANES(PLANES), .ADDR_W(ADDR_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .owner     (owner),
    .host_we   (host_we),
    .host_addr (host_addr),
    .disp_addr (disp_addr),
    .map_mask  (map_mask),
    .mem_cyc   (mem_cyc),
    .mem_host  (mem_host),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
  );

  assign host_ack = host_gnt;
  assign disp_ack = disp_gnt;

  // R2
  host_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && active) |-> (slot == SW'(HOST_SLOT)));

  // R7
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_ack && disp_ack));

  // R7
  host_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> (mem_cyc && mem_host && mem_addr == $past(host_addr)));

  // R1
  char_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> char_clk);

  // R5
  blank_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && host_req) |-> (host_ack && host_slot_open));

endmodule

// File: tb/tb_dmseq_top.sv
`timescale 1ns/1ps
module tb_dmseq_top;
  localparam int SLOTS  = 8;
  localparam int HS     = SLOTS - 1;
  localparam int PLANES = 4;
  localparam int AW     = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic act, dreq, hreq, hwe;
  logic [AW-1:0] daddr, haddr;
  logic [PLANES-1:0] mask;
  logic dack, hack, cclk, mcyc, mhost;
  logic [AW-1:0] maddr;
  logic [PLANES-1:0] mwe, mre;

  int checks = 0;
  int errors = 0;
  int eslot  = 0;
  logic [PLANES-1:0] last_we;

  always #2 clk = ~clk;

  dmseq_top dut (
    .clk(clk), .rst_n(rst_n), .active(act), .disp_req(dreq), .disp_addr(daddr),
    .disp_ack(dack), .host_req(hreq), .host_we(hwe), .host_addr(haddr),
    .map_mask(mask), .host_ack(hack), .char_clk(cclk), .mem_cyc(mcyc),
    .mem_host(mhost), .mem_addr(maddr), .mem_we(mwe), .mem_re(mre)
  );

  task automatic chk(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h slot=%0d t=%0t", tag, actual, expected, eslot, $time);
    end
  endtask

  function automatic bit exp_host(bit a, bit r, int s);
    return r && (!a || s == HS);
  endfunction

  // one clock: inputs already driven at a falling edge
  task automatic step();
    bit eh, ed;
    logic [AW-1:0] ea;
    logic [PLANES-1:0] ew, er;
    #1;
    eh = exp_host(act, hreq, eslot);
    ed = dreq && !eh;
    chk(hack == eh, act ? "R2 host grant in active" : "R5 host grant in blanking", hack, eh);
    if (!act)              chk(dack == ed, "R5 display yields in blanking", dack, ed);
    else if (eslot != HS)  chk(dack == ed, "R3 display owns slot", dack, ed);
    else                   chk(dack == ed, "R4 reserved slot to display", dack, ed);
    if (hreq && !eh)       chk(hack == 1'b0, "R6 ack low while waiting", hack, 0);
    chk(cclk == (eslot < SLOTS / 2), "R1 char clock", cclk, eslot < SLOTS / 2);
    ea = eh ? haddr : (ed ? daddr : '0);
    ew = (eh && hwe) ? mask : '0;
    er = (ed || (eh && !hwe)) ? '1 : '0;
    @(posedge clk);
    eslot = (eslot + 1) % SLOTS;
    @(negedge clk);
    if (eh || ed) begin
      chk(mcyc && mhost == eh, "R7 cycle owner", {mcyc, mhost}, {1'b1, eh});
      chk(maddr == ea, "R7 issued address", maddr, ea);
      chk(mwe == ew, "R8 plane write enables", mwe, ew);
      chk(mre == er, "R9 plane read enables", mre, er);
    end else begin
      chk({mcyc, mhost, mwe, mre} == '0 && maddr == '0, "R10 idle outputs",
          {mcyc, mhost, mwe, mre}, 0);
    end
    last_we = mwe;
    if (eh) hreq = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; act = 1'b0; dreq = 1'b0; hreq = 1'b0; hwe = 1'b0;
    daddr = '0; haddr = '0; mask = '0; last_we = '0;
    repeat (4) @(negedge clk);
    chk({mcyc, mhost, mwe, mre} == '0, "R10 reset outputs", {mcyc, mhost, mwe, mre}, 0);
    chk(cclk == 1'b1, "R1 char clock at reset", cclk, 1);
    rst_n = 1'b1;
    eslot = 0;

    // R4: reserved slot, no host waiting, display takes it
    act = 1'b1; dreq = 1'b1; daddr = 16'h1234;
    while (eslot != HS) step();
    step();
    // R4: reserved slot with host waiting, host takes it
    while (eslot != 2) step();
    hreq = 1'b1; hwe = 1'b0; haddr = 16'hBEEF;
    while (hreq) step();

    // R11: mask changed while the write waits; grant-time value wins
    dreq = 1'b0;
    while (eslot != 1) step();
    hreq = 1'b1; hwe = 1'b1; haddr = 16'h0F0F; mask = 4'b0101;
    while (eslot != 5) step();
    mask = 4'b1010;
    while (hreq) step();
    chk(last_we == 4'b1010, "R11 mask taken at grant", last_we, 4'b1010);
    // R11: change after the grant does not touch the issued write
    hreq = 1'b1; haddr = 16'h0001; mask = 4'b0011;
    while (hreq) begin
      step();
    end
    mask = 4'b1100;
    chk(last_we == 4'b0011, "R11 later change ignored", last_we, 4'b0011);

    // R8: zero mask writes nothing, in blanking
    act = 1'b0; hreq = 1'b1; hwe = 1'b1; mask = 4'b0000; dreq = 1'b1;
    while (hreq) step();
    chk(last_we == 4'b0000, "R8 zero mask", last_we, 0);

    // R5: back-to-back host grants during blanking
    for (int i = 0; i < 5; i++) begin
      hreq = 1'b1; hwe = i[0]; haddr = 16'(i * 7); mask = 4'(i + 1);
      step();
    end

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) act = ~act;
      dreq  = act ? ($urandom_range(0, 9) < 7) : ($urandom_range(0, 9) < 2);
      daddr = 16'($urandom);
      if (!hreq && $urandom_range(0, 9) < 3) begin
        hreq  = 1'b1;
        hwe   = $urandom_range(0, 1) == 1;
        haddr = 16'($urandom);
      end
      if ($urandom_range(0, 9) == 0) mask = 4'($urandom);
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule